// File: doc/BRIEF.md
# Channel Epoch Counter and Measurement Latch

This block keeps the millisecond timing of one correlator channel of a satellite-navigation receiver. A half-chip strobe from the code DCO drives a half-chip phase counter, and that counter's period depends on the code mode: 2046 half-chips in the wide mode and 1022 in the narrow mode. Each time the phase counter rolls over, a one-millisecond epoch counter (0 to 19) advances. When that counter wraps, a twenty-millisecond epoch counter (0 to 49) advances in turn. Software can load both epoch counters to align them with the navigation data.

A measurement strobe captures the two epoch counters, the half-chip phase and the top byte of the code DCO phase accumulator into two 16-bit measurement words. A capture raises a status flag. While that flag is high the words are protected, and further measurement strobes are ignored until a measurement-reset write releases them. A per-channel reset strobe and a global reset strobe both do this. A third word gives an unlatched view of both epoch counters and is refreshed on every accumulation dump strobe.

Top module: `chan_epoch_latch`

## Requirements
- R1: After a synchronous reset, the phase counter, both epoch counters, both measurement words, the check word and `meas_valid_o` are all zero.
- R2: Each cycle with `half_chip_i` high advances the phase counter by one. When a tick arrives with the counter at or above its limit, the counter goes to 0 and the one-millisecond counter steps. The limit is 2045 when `mode_i`=0 and 1021 when `mode_i`=1.
- R3: The one-millisecond counter wraps from 19 to 0. At that wrap, and only then, the twenty-millisecond counter steps, and it wraps from 49 to 0.
- R4: With `ep_wr_i` high, both epoch counters take `ep_ms1_i` and `ep_ms20_i` at the next edge. The load wins over a step in the same cycle. The phase counter still advances in that cycle.
- R5: A measurement strobe `tic_i` with `meas_valid_o` low updates the words at the next edge. `meas_a_o` gets the one-millisecond count in bits 15:11 and the phase in bits 10:0. `meas_b_o` gets zero in bits 15:14, the twenty-millisecond count in bits 13:8 and the top 8 bits of `dco_phase_i` in bits 7:0. All values are those present in the cycle of the strobe.
- R6: While `meas_valid_o` is high, a measurement strobe leaves both measurement words unchanged.
- R7: `meas_valid_o` goes high at the edge after a capture and stays high until a release.
- R8: A strobe on `meas_rel_ch_i` or `meas_rel_all_i` clears `meas_valid_o` at the next edge. If a measurement strobe arrives in the same cycle while protected, it is dropped. If it arrives in the same cycle while unprotected, it captures and `meas_valid_o` ends high.
- R9: On `dump_i`, `chk_o` takes zero in bits 15:13, the one-millisecond count in bits 12:8, zero in bits 7:6 and the twenty-millisecond count in bits 5:0. Without `dump_i` it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_chip_i | input | 1 | Half-chip advance strobe |
| mode_i | input | 1 | Code mode: 0 wide (2046), 1 narrow (1022) |
| dco_phase_i | input | DCO_W | Code DCO phase accumulator |
| tic_i | input | 1 | Measurement capture strobe |
| dump_i | input | 1 | Accumulation dump strobe |
| ep_wr_i | input | 1 | Epoch counter load strobe |
| ep_ms1_i | input | 5 | One-millisecond load value |
| ep_ms20_i | input | 6 | Twenty-millisecond load value |
| meas_rel_ch_i | input | 1 | Per-channel measurement reset write |
| meas_rel_all_i | input | 1 | Global measurement reset write |
| meas_a_o | output | 16 | Measurement word A |
| meas_b_o | output | 16 | Measurement word B |
| chk_o | output | 16 | Unlatched epoch check word |
| meas_valid_o | output | 1 | Capture status and protection flag |

## Verification
The hardest case to reach is the twenty-millisecond wrap. Reaching it by counting alone would take a thousand code periods. The bench instead loads 19 and 49 and then drives one full code period of half-chip strobes. Two cases need an exact cycle arrangement: a mode change while the phase counter sits above the narrow limit, and a measurement strobe in the same cycle as a release. The bench steers its own phase model to the value it needs and then issues the strobes together. The captured words arrive in a scoreboard queue and are compared when the status flag rises.

// File: rtl/chan_epoch_pkg.sv
package chan_epoch_pkg;
  localparam int PH_W        = 11;
  localparam int MS1_W       = 5;
  localparam int MS20_W      = 6;
  localparam int WORD_W      = 16;
  localparam int DCO_TOP_W   = 8;
  localparam int MS1_LAST    = 19;
  localparam int MS20_LAST   = 49;
  localparam int PH_LAST_WIDE   = 2045;
  localparam int PH_LAST_NARROW = 1021;

  typedef enum logic {MODE_WIDE = 1'b0, MODE_NARROW = 1'b1} code_mode_e;

  typedef struct packed {
    logic [MS1_W-1:0] ms1;
    logic [PH_W-1:0]  phase;
  } meas_a_t;

  typedef struct packed {
    logic [1:0]           pad;
    logic [MS20_W-1:0]    ms20;
    logic [DCO_TOP_W-1:0] dco;
  } meas_b_t;

  typedef struct packed {
    logic [2:0]        pad_hi;
    logic [MS1_W-1:0]  ms1;
    logic [1:0]        pad_lo;
    logic [MS20_W-1:0] ms20;
  } chk_t;
endpackage

// File: rtl/epoch_mod_counter.sv
module epoch_mod_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic at_end;

  assign at_end = (cnt >= last);
  assign wrap   = step && !ld && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld) begin
      cnt <= ld_val;
    end else if (step) begin
      cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/meas_latch.sv
module meas_latch #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tic,
  input  logic              rel,
  input  logic [WORD_W-1:0] a_in,
  input  logic [WORD_W-1:0] b_in,
  output logic [WORD_W-1:0] a_q,
  output logic [WORD_W-1:0] b_q,
  output logic              valid_q
);
  logic take;

  assign take = tic && !valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q     <= '0;
      b_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      if (take) begin
        a_q <= a_in;
        b_q <= b_in;
      end
      if (take) begin
        valid_q <= 1'b1;
      end else if (rel) begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/chan_epoch_latch.sv
module chan_epoch_latch
  import chan_epoch_pkg::*;
#(
  parameter int DCO_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_chip_i,
  input  logic              mode_i,
  input  logic [DCO_W-1:0]  dco_phase_i,
  input  logic              tic_i,
  input  logic              dump_i,
  input  logic              ep_wr_i,
  input  logic [MS1_W-1:0]  ep_ms1_i,
  input  logic [MS20_W-1:0] ep_ms20_i,
  input  logic              meas_rel_ch_i,
  input  logic              meas_rel_all_i,
  output logic [WORD_W-1:0] meas_a_o,
  output logic [WORD_W-1:0] meas_b_o,
  output logic [WORD_W-1:0] chk_o,
  output logic              meas_valid_o
);
  localparam logic [PH_W-1:0]   PH_LIM_W  = PH_W'(PH_LAST_WIDE);
  localparam logic [PH_W-1:0]   PH_LIM_N  = PH_W'(PH_LAST_NARROW);
  localparam logic [MS1_W-1:0]  MS1_LIM   = MS1_W'(MS1_LAST);
  localparam logic [MS20_W-1:0] MS20_LIM  = MS20_W'(MS20_LAST);

  logic [PH_W-1:0]   ph_q;
  logic [PH_W-1:0]   ph_lim;
  logic [MS1_W-1:0]  ms1_q;
  logic [MS20_W-1:0] ms20_q;
  logic              ph_wrap;
  logic              ms1_wrap;
  logic              ms20_wrap;
  meas_a_t           a_next;
  meas_b_t           b_next;
  chk_t              chk_next;
  logic              rel;

  assign ph_lim = (code_mode_e'(mode_i) == MODE_NARROW) ? PH_LIM_N : PH_LIM_W;

  epoch_mod_counter #(.W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .ld(1'b0), .ld_val('0), .step(half_chip_i),
    .last(ph_lim), .cnt(ph_q), .wrap(ph_wrap)
  );

  epoch_mod_counter #(.W(MS1_W)) u_ms1 (
    .clk(clk), .rst(rst), .ld(ep_wr_i), .ld_val(ep_ms1_i), .step(ph_wrap),
    .last(MS1_LIM), .cnt(ms1_q), .wrap(ms1_wrap)
  );

  epoch_mod_counter #(.W(MS20_W)) u_ms20 (
    .clk(clk), .rst(rst), .ld(ep_wr_i), .ld_val(ep_ms20_i), .step(ms1_wrap),
    .last(MS20_LIM), .cnt(ms20_q), .wrap(ms20_wrap)
  );

  always_comb begin
    a_next.ms1     = ms1_q;
    a_next.phase   = ph_q;
    b_next.pad     = 2'b00;
    b_next.ms20    = ms20_q;
    b_next.dco     = dco_phase_i[DCO_W-1 -: DCO_TOP_W];
    chk_next.pad_hi = 3'b000;
    chk_next.ms1    = ms1_q;
    chk_next.pad_lo = 2'b00;
    chk_next.ms20   = ms20_q;
  end

  assign rel = meas_rel_ch_i || meas_rel_all_i;

  meas_latch #(.WORD_W(WORD_W)) u_latch (
    .clk(clk), .rst(rst), .tic(tic_i), .rel(rel),
    .a_in(a_next), .b_in(b_next),
    .a_q(meas_a_o), .b_q(meas_b_o), .valid_q(meas_valid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_o <= '0;
    end else if (dump_i) begin
      chk_o <= chk_next;
    end
  end

  logic unused_wrap;
  assign unused_wrap = ms20_wrap;
endmodule

// File: rtl/chan_epoch_chk.sv
module chan_epoch_chk (
  input logic        clk,
  input logic        rst,
  input logic        tic,
  input logic        rel,
  input logic        half_chip,
  input logic        mode,
  input logic        ep_wr,
  input logic [4:0]  ep_ms1,
  input logic [5:0]  ep_ms20,
  input logic        dump,
  input logic        ph_wrap,
  input logic [10:0] phase,
  input logic [4:0]  ms1,
  input logic [5:0]  ms20,
  input logic [15:0] meas_a,
  input logic [15:0] meas_b,
  input logic [15:0] chk,
  input logic        valid
);
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    $past(half_chip) |-> (phase <= ($past(mode) ? 11'd1021 : 11'd2045))); // R2

  AST_MS1_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!ep_wr && ph_wrap && ms1 == 5'd19) |=> (ms1 == 5'd0)); // R3

  AST_MS20_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ep_wr && ph_wrap && ms1 == 5'd19) |=>
      (ms20 == (($past(ms20) == 6'd49) ? 6'd0 : $past(ms20) + 6'd1))); // R3

  AST_EPOCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    ep_wr |=> (ms1 == $past(ep_ms1) && ms20 == $past(ep_ms20))); // R4

  AST_HOLD_PROTECTED: assert property (@(posedge clk) disable iff (rst)
    valid |=> ($stable(meas_a) && $stable(meas_b))); // R6

  AST_CAPTURE_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    (tic && !valid) |=> valid); // R7

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rel && !tic) |=> !valid); // R8

  AST_CHK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dump |=> $stable(chk)); // R9
endmodule

bind chan_epoch_latch chan_epoch_chk u_chan_epoch_chk (
  .clk(clk), .rst(rst), .tic(tic_i), .rel(rel), .half_chip(half_chip_i),
  .mode(mode_i), .ep_wr(ep_wr_i), .ep_ms1(ep_ms1_i), .ep_ms20(ep_ms20_i),
  .dump(dump_i), .ph_wrap(ph_wrap), .phase(ph_q), .ms1(ms1_q), .ms20(ms20_q),
  .meas_a(meas_a_o), .meas_b(meas_b_o), .chk(chk_o), .valid(meas_valid_o)
);

// File: tb/chan_epoch_latch_bench.sv
module chan_epoch_latch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DCO_W = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic half_chip_i = 0, mode_i = 0, tic_i = 0, dump_i = 0, ep_wr_i = 0;
  logic meas_rel_ch_i = 0, meas_rel_all_i = 0;
  logic [DCO_W-1:0] dco_phase_i = '0;
  logic [4:0] ep_ms1_i = '0;
  logic [5:0] ep_ms20_i = '0;
  logic [15:0] meas_a_o, meas_b_o, chk_o;
  logic meas_valid_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_epoch_latch #(.DCO_W(DCO_W)) u_chan_epoch_latch (.*);

  typedef struct packed { logic [15:0] a; logic [15:0] b; } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  logic done = 1'b0;

  int m_ph = 0, m1 = 0, m20 = 0;
  logic m_valid = 0;
  logic [15:0] m_a = 0, m_b = 0, m_chk = 0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock with the strobes currently driven; model updated from pre-edge state
  task automatic clk_step();
    int lim;
    logic wrapped;
    exp_t e;
    lim = mode_i ? 1021 : 2045;
    if (tic_i && !m_valid) begin
      e.a = {5'(m1), 11'(m_ph)};
      e.b = {2'b00, 6'(m20), dco_phase_i[DCO_W-1 -: 8]};
      m_a = e.a; m_b = e.b;
      q.push_back(e);
      m_valid = 1'b1;
    end else if (meas_rel_ch_i || meas_rel_all_i) begin
      m_valid = 1'b0;
    end
    if (dump_i) m_chk = {3'b000, 5'(m1), 2'b00, 6'(m20)};
    wrapped = 1'b0;
    if (half_chip_i) begin
      if (m_ph >= lim) begin m_ph = 0; wrapped = 1'b1; end
      else m_ph++;
    end
    if (ep_wr_i) begin
      m1 = int'(ep_ms1_i); m20 = int'(ep_ms20_i);
    end else if (wrapped) begin
      if (m1 >= 19) begin
        m1 = 0;
        m20 = (m20 >= 49) ? 0 : m20 + 1;
      end else m1++;
    end
    @(posedge clk);
    #1;
    half_chip_i = 0; tic_i = 0; dump_i = 0; ep_wr_i = 0;
    meas_rel_ch_i = 0; meas_rel_all_i = 0;
  endtask

  task automatic run_hc(input int n);
    for (int i = 0; i < n; i++) begin
      half_chip_i = 1;
      clk_step();
    end
  endtask

  task automatic do_dump_check(input string req);
    dump_i = 1;
    clk_step();
    check(req, chk_o, m_chk);
  endtask

  // monitor: pops an expected capture each time the status flag rises
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst && meas_valid_o && !prev) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 unexpected capture actual=%h_%h expected=none", meas_a_o, meas_b_o);
        end else begin
          exp_t e;
          e = q.pop_front();
          check("R5 word A", meas_a_o, e.a);
          check("R5 word B", meas_b_o, e.b);
        end
      end
      prev = rst ? 1'b0 : meas_valid_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    check("R1 word A", meas_a_o, 16'h0);
    check("R1 word B", meas_b_o, 16'h0);
    check("R1 chk", chk_o, 16'h0);
    check("R1 valid", {15'b0, meas_valid_o}, 16'h0);

    // R2 wide mode: one full period steps ms1
    run_hc(2046);
    do_dump_check("R2 wide period");
    check("R2 ms1 after wide period", {11'b0, chk_o[12:8]}, 16'd1);

    // R5/R7 capture
    run_hc(37);
    dco_phase_i = 24'hA5_1234;
    tic_i = 1; clk_step();
    check("R7 valid set", {15'b0, meas_valid_o}, 16'h1);

    // R6 protected strobe ignored
    run_hc(5);
    dco_phase_i = 24'h3C_0000;
    tic_i = 1; clk_step();
    check("R6 word A held", meas_a_o, m_a);
    check("R6 word B held", meas_b_o, m_b);
    check("R7 valid held", {15'b0, meas_valid_o}, 16'h1);

    // R8 per-channel release
    meas_rel_ch_i = 1; clk_step();
    check("R8 release ch", {15'b0, meas_valid_o}, 16'h0);

    // R4 load, then R3 double wrap
    while (m_ph != 0) run_hc(1);
    ep_wr_i = 1; ep_ms1_i = 5'd19; ep_ms20_i = 6'd49; clk_step();
    do_dump_check("R4 load 19/49");
    run_hc(2046);
    do_dump_check("R3 wrap 49 to 0");
    check("R3 ms20 zero", {10'b0, chk_o[5:0]}, 16'd0);

    ep_wr_i = 1; ep_ms1_i = 5'd19; ep_ms20_i = 6'd10; clk_step();
    run_hc(2046);
    do_dump_check("R3 ms20 step 10 to 11");

    // R4 load beats a step in the same cycle
    while (m_ph != 2045) run_hc(1);
    ep_wr_i = 1; ep_ms1_i = 5'd7; ep_ms20_i = 6'd3; half_chip_i = 1; clk_step();
    do_dump_check("R4 load priority");
    check("R4 ms1 loaded", {11'b0, chk_o[12:8]}, 16'd7);

    // R9 chk holds without dump
    run_hc(3000);
    check("R9 chk held", chk_o, m_chk);

    // R2 narrow mode period
    mode_i = 1;
    while (m_ph != 0) run_hc(1);
    run_hc(1022);
    do_dump_check("R2 narrow period");

    // R2 mode switch while above narrow limit
    mode_i = 0;
    while (m_ph != 1500) run_hc(1);
    mode_i = 1;
    run_hc(1);
    dco_phase_i = 24'hFF_FFFF;
    tic_i = 1; clk_step();
    check("R2 phase after switch", {5'b0, meas_a_o[10:0]}, 16'd0);

    // R8 protected strobe with release: dropped, flag clears
    run_hc(9);
    tic_i = 1; meas_rel_all_i = 1; clk_step();
    check("R8 dropped A", meas_a_o, m_a);
    check("R8 flag cleared", {15'b0, meas_valid_o}, 16'h0);

    // R8 unprotected strobe with release: captures, flag high
    run_hc(4);
    dco_phase_i = 24'h5A_0000;
    tic_i = 1; meas_rel_ch_i = 1; clk_step();
    check("R8 capture with release", {15'b0, meas_valid_o}, 16'h1);
    check("R8 word B", meas_b_o, m_b);

    meas_rel_all_i = 1; clk_step();
    check("R8 release all", {15'b0, meas_valid_o}, 16'h0);

    repeat (2) @(posedge clk);
    #1;
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R5 pending captures actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule